// File: doc/BRIEF.md
# Power-of-Two Weighted Shift-Accumulate Neuron

This block computes the pre-activation sum of a quantized neuron without using any multiplier. Activations are unsigned and narrow. They arrive one vector element at a time. With each element come compact weight codes. A code selects a signed power of two or an exact zero. The product is therefore a left shift, or a plain select in the ternary variant, followed by conditional two's-complement negation. Each product is added into the accumulator of its neuron. After the last element of the vector, the sum is arithmetically shifted right, saturated to a signed output width and reported for one cycle.

The parameter `FOLD` sets how many logical neurons share one adder. Every element is held at the input for `FOLD` cycles. In each of those cycles the shared adder serves one neuron, with that neuron's weight code picked from a packed code bus. Each neuron keeps its own partial-sum register. The results are the same as with one adder per neuron, and the latency is multiplied by `FOLD`. The parameter `TERNARY` selects either the 3-bit weight code or the 2-bit ternary code.

Top module: `shift_neuron`

## Requirements
- R1: After reset, `ready_o` and `done_o` are low and every lane of `res_o` is zero.
- R2: With `TERNARY`=0 a code is 3 bits: bit 2 is the sign (1 = negative) and bits 1:0 give the magnitude: 00 = zero, 01 = ×1, 10 = ×2, 11 = ×4.
- R3: With `TERNARY`=1 a code is 2 bits: bit 1 is the sign and bit 0 selects the activation (1) or zero (0), so the weight is one of -1, 0 and +1.
- R4: The accumulator holds `ACT_W`+1+largest shift+ceil(log2(`N_IN`)) bits, and no running sum wraps, even at full-scale activations and weights.
- R5: A vector is exactly `N_IN` elements, applied serially, and each element is applied with `valid_i` high.
- R6: Each element is consumed after `FOLD` cycles with `valid_i` high. `ready_o` is high only in the last of those cycles. Neuron k takes its code from `wcode_i[k*CODE_W +: CODE_W]`, and each neuron's result equals its own unfolded sum.
- R7: A zero-magnitude code, with either sign, adds nothing to the sum and still occupies its cycle.
- R8: Each result lane is the sum arithmetically shifted right by `OUT_SHR` and saturated to the signed `OUT_W` range. Lane k sits at `res_o[k*OUT_W +: OUT_W]`.
- R9: `done_o` is high for exactly one cycle, the cycle after the final element is consumed. `res_o` holds its value from that cycle until the next accepted start.
- R10: A `start_i` pulse while idle clears all sums and begins a vector. A `start_i` pulse while a vector is in progress is ignored.
- R11: While idle, `valid_i` is ignored: `ready_o` and `done_o` stay low and `res_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new vector (only while idle) |
| valid_i | input | 1 | Activation and codes are present |
| act_i | input | ACT_W | Unsigned activation element |
| wcode_i | input | FOLD*CODE_W | Packed weight codes, one per logical neuron |
| ready_o | output | 1 | Element consumed on this clock edge |
| done_o | output | 1 | One-cycle result strobe |
| res_o | output | FOLD*OUT_W | Packed saturated results, one lane per neuron |

## Verification
The hardest state to reach from the ports is a running sum near the accumulator limit that must not wrap. It is reached with full-scale activations under ×4 codes. One lane climbs to the maximum. The other lane climbs halfway and then descends back to exactly zero, so any wrap would show up in the final value. Start pulses placed in the middle of a vector and valid pulses while idle show that both are ignored. The number of cycles each element waits for `ready_o` is counted, which checks the fold schedule.

// File: rtl/shn_pkg.sv
package shn_pkg;
  function automatic int code_width(input bit ternary);
    return ternary ? 2 : 3;
  endfunction

  function automatic int max_shift(input bit ternary);
    return ternary ? 0 : 2;
  endfunction

  function automatic int ceil_log2(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction
endpackage

// File: rtl/shn_weight_mux.sv
module shn_weight_mux #(
  parameter int ACT_W   = 6,
  parameter bit TERNARY = 1'b0,
  parameter int CODE_W  = 3,
  parameter int MAG_W   = 8
) (
  input  logic [ACT_W-1:0]  act_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [MAG_W-1:0]  mag_o,
  output logic              neg_o
);
  logic [MAG_W-1:0] act_ext;
  assign act_ext = MAG_W'(act_i);

  generate
    if (TERNARY) begin : g_tern
      // plain select; sign handled downstream by xor + carry
      assign mag_o = code_i[0] ? act_ext : '0;
      assign neg_o = code_i[1];
    end else begin : g_pot
      always_comb begin
        unique case (code_i[1:0])
          2'b00:   mag_o = '0;
          2'b01:   mag_o = act_ext;
          2'b10:   mag_o = act_ext << 1;
          default: mag_o = act_ext << 2;
        endcase
      end
      assign neg_o = code_i[2];
    end
  endgenerate
endmodule

// File: rtl/shn_ctrl.sv
module shn_ctrl #(
  parameter int FOLD   = 2,
  parameter int N_IN   = 16,
  parameter int SLOT_W = 1,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  output logic              clear_o,
  output logic              step_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              ready_o,
  output logic              done_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FOLD - 1);
  localparam logic [CNT_W-1:0]  LAST_ELEM = CNT_W'(N_IN - 1);

  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              last_slot, last_elem;

  assign clear_o   = start_i & ~busy_q;
  assign step_o    = busy_q & valid_i;
  assign last_slot = (slot_q == LAST_SLOT);
  assign last_elem = (cnt_q == LAST_ELEM);
  assign ready_o   = step_o & last_slot;
  assign slot_o    = slot_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= ready_o & last_elem;
      if (clear_o) begin
        busy_q <= 1'b1;
        slot_q <= '0;
        cnt_q  <= '0;
      end else if (step_o) begin
        if (last_slot) begin
          slot_q <= '0;
          if (last_elem) busy_q <= 1'b0;
          else           cnt_q  <= cnt_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  assert_idle_no_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !ready_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_after_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(ready_o));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !ready_o) |=> busy_q);
  assert_slot_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST_SLOT);
endmodule

// File: rtl/shn_acc_bank.sv
module shn_acc_bank #(
  parameter int FOLD   = 2,
  parameter int ACC_W  = 13,
  parameter int MAG_W  = 8,
  parameter int SLOT_W = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  en_i,
  input  logic [SLOT_W-1:0]     slot_i,
  input  logic [MAG_W-1:0]      mag_i,
  input  logic                  neg_i,
  output logic [FOLD*ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q [FOLD];
  logic [ACC_W-1:0] cur, addend, sum;
  logic [ACC_W:0]   wide;

  assign cur    = acc_q[slot_i];
  assign addend = ACC_W'(mag_i) ^ {ACC_W{neg_i}};
  // single shared adder, negation via carry-in
  assign sum    = cur + addend + ACC_W'(neg_i);
  assign wide   = {cur[ACC_W-1], cur} + {addend[ACC_W-1], addend} + (ACC_W+1)'(neg_i);

  for (genvar k = 0; k < FOLD; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                acc_q[k] <= '0;
      else if (clear_i)                           acc_q[k] <= '0;
      else if (en_i && slot_i == SLOT_W'(k))      acc_q[k] <= sum;
    end
    assign acc_o[k*ACC_W +: ACC_W] = acc_q[k];
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (wide[ACC_W] == wide[ACC_W-1]));
  assert_clear_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_o == '0));
endmodule

// File: rtl/shn_requant.sv
module shn_requant #(
  parameter int ACC_W   = 13,
  parameter int OUT_W   = 6,
  parameter int OUT_SHR = 2
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] q_o
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO = -ACC_W'(1 << (OUT_W - 1));

  logic signed [ACC_W-1:0] shr;
  assign shr = $signed(acc_i) >>> OUT_SHR;

  always_comb begin
    if (shr > HI)      q_o = HI[OUT_W-1:0];
    else if (shr < LO) q_o = LO[OUT_W-1:0];
    else               q_o = shr[OUT_W-1:0];
  end
endmodule

// File: rtl/shift_neuron.sv
module shift_neuron
  import shn_pkg::*;
#(
  parameter int ACT_W   = 6,
  parameter int N_IN    = 16,
  parameter int FOLD    = 2,
  parameter bit TERNARY = 1'b0,
  parameter int OUT_W   = 6,
  parameter int OUT_SHR = 2,
  parameter int CODE_W  = code_width(TERNARY)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   valid_i,
  input  logic [ACT_W-1:0]       act_i,
  input  logic [FOLD*CODE_W-1:0] wcode_i,
  output logic                   ready_o,
  output logic                   done_o,
  output logic [FOLD*OUT_W-1:0]  res_o
);
  localparam int MAX_SH = max_shift(TERNARY);
  localparam int MAG_W  = ACT_W + MAX_SH;
  localparam int ACC_W  = ACT_W + 1 + MAX_SH + ceil_log2(N_IN);
  localparam int SLOT_W = (FOLD > 1) ? ceil_log2(FOLD) : 1;
  localparam int CNT_W  = (N_IN > 1) ? ceil_log2(N_IN) : 1;

  logic              clear, step;
  logic [SLOT_W-1:0] slot;
  logic [CODE_W-1:0] code_sel;
  logic [MAG_W-1:0]  mag;
  logic              neg;
  logic [FOLD*ACC_W-1:0] acc;

  shn_ctrl #(.FOLD(FOLD), .N_IN(N_IN), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .valid_i,
    .clear_o(clear), .step_o(step), .slot_o(slot),
    .ready_o, .done_o
  );

  assign code_sel = wcode_i[slot*CODE_W +: CODE_W];

  shn_weight_mux #(.ACT_W(ACT_W), .TERNARY(TERNARY), .CODE_W(CODE_W), .MAG_W(MAG_W)) u_wmux (
    .act_i, .code_i(code_sel), .mag_o(mag), .neg_o(neg)
  );

  shn_acc_bank #(.FOLD(FOLD), .ACC_W(ACC_W), .MAG_W(MAG_W), .SLOT_W(SLOT_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(clear), .en_i(step), .slot_i(slot),
    .mag_i(mag), .neg_i(neg), .acc_o(acc)
  );

  for (genvar k = 0; k < FOLD; k++) begin : g_rq
    shn_requant #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHR(OUT_SHR)) u_rq (
      .acc_i(acc[k*ACC_W +: ACC_W]), .q_o(res_o[k*OUT_W +: OUT_W])
    );
  end

  assert_res_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !clear) |=> $stable(res_o));
endmodule

// File: tb/tb_shift_neuron.sv
module tb_shift_neuron;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int F = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       start_i = 0, valid_i = 0;
  logic [5:0] act_i = 0;
  logic [5:0] wcode_i = 0;
  logic       ready_o, done_o;
  logic [11:0] res_o;

  logic       t_start = 0, t_valid = 0;
  logic [5:0] t_act = 0;
  logic [1:0] t_code = 0;
  logic       t_ready, t_done;
  logic [7:0] t_res;

  shift_neuron #(.ACT_W(6), .N_IN(N), .FOLD(F), .TERNARY(1'b0), .OUT_W(6), .OUT_SHR(2)) dut (
    .clk_i(clk), .rst_ni, .start_i, .valid_i, .act_i, .wcode_i,
    .ready_o, .done_o, .res_o
  );

  shift_neuron #(.ACT_W(6), .N_IN(N), .FOLD(1), .TERNARY(1'b1), .OUT_W(8), .OUT_SHR(0)) dut_t (
    .clk_i(clk), .rst_ni, .start_i(t_start), .valid_i(t_valid), .act_i(t_act),
    .wcode_i(t_code), .ready_o(t_ready), .done_o(t_done), .res_o(t_res)
  );

  int nchk = 0, nbad = 0;
  logic [5:0] act_v [N];
  logic [2:0] code_v [F][N];
  logic [1:0] tcode_v [N];
  int unsigned seed = 32'h1234_5678;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt();
    seed = seed * 1103515245 + 12345;
    return int'(seed >> 16);
  endfunction

  function automatic int prod3(int a, logic [2:0] c);
    int v;
    v = (c[1:0] == 2'b00) ? 0 : (a << (c[1:0] - 1));
    return c[2] ? -v : v;
  endfunction

  function automatic int rq(int s, int shr, int w);
    int q, hi, lo;
    q  = s >>> shr;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    return (q > hi) ? hi : ((q < lo) ? lo : q);
  endfunction

  function automatic int lane(int k);
    logic [5:0] b;
    b = res_o[k*6 +: 6];
    return int'($signed(b));
  endfunction

  // drive one vector into dut; start_at >= 0 pulses start during that element
  task automatic run_main(string tag, int start_at);
    int e0, e1, cyc, badcyc;
    e0 = 0; e1 = 0; badcyc = 0;
    for (int e = 0; e < N; e++) begin
      e0 += prod3(act_v[e], code_v[0][e]);
      e1 += prod3(act_v[e], code_v[1][e]);
    end
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int e = 0; e < N; e++) begin
      act_i = act_v[e];
      wcode_i = {code_v[1][e], code_v[0][e]};
      valid_i = 1;
      if (e == start_at) start_i = 1;
      cyc = 0;
      #1;
      while (!ready_o) begin
        @(negedge clk); start_i = 0; #1; cyc++;
        if (cyc > 8) break;
      end
      if (cyc != F - 1) badcyc++;
      @(negedge clk); start_i = 0;
    end
    valid_i = 0;
    #1;
    check({tag, " R6 fold cycles/element"}, badcyc, 0);
    check({tag, " R9 done strobe"}, done_o, 1);
    check({tag, " R8 lane0"}, lane(0), rq(e0, 2, 6));
    check({tag, " R8 lane1"}, lane(1), rq(e1, 2, 6));
    @(negedge clk); #1;
    check({tag, " R9 done single"}, done_o, 0);
    check({tag, " R9 lane0 hold"}, lane(0), rq(e0, 2, 6));
  endtask

  task automatic test_reset();
    #1;
    check("R1 ready", ready_o, 0);
    check("R1 done", done_o, 0);
    check("R1 res", res_o, 0);
    check("R1 ternary res", t_res, 0);
  endtask

  task automatic test_codes();
    // R2: each magnitude and sign; lane0 positive, lane1 negative
    for (int e = 0; e < N; e++) begin
      act_v[e] = 6'(e + 1);
      code_v[0][e] = {1'b0, 2'(e % 4)};
      code_v[1][e] = {1'b1, 2'((e + 1) % 4)};
    end
    run_main("R2 codes", -1);
  endtask

  task automatic test_random();
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < N; e++) begin
        act_v[e] = 6'(nxt());
        code_v[0][e] = 3'(nxt());
        code_v[1][e] = 3'(nxt());
      end
      run_main("R5 mixed", -1);
    end
  endtask

  task automatic test_full_scale();
    // R4: lane0 climbs to max; lane1 up to half then back to exact zero
    for (int e = 0; e < N; e++) begin
      act_v[e] = 6'd63;
      code_v[0][e] = 3'b011;
      code_v[1][e] = (e < N/2) ? 3'b011 : 3'b111;
    end
    run_main("R4 full", -1);
    check("R4 lane1 returns to zero", lane(1), 0);
    for (int e = 0; e < N; e++) code_v[0][e] = 3'b111;
    run_main("R4 neg full", -1);
    check("R8 neg saturate", lane(0), -32);
  endtask

  task automatic test_zero_codes();
    for (int e = 0; e < N; e++) begin
      act_v[e] = 6'd63;
      code_v[0][e] = 3'b000;
      code_v[1][e] = 3'b100;
    end
    run_main("R7 zero", -1);
    check("R7 lane1 zero", lane(1), 0);
  endtask

  task automatic test_start_busy();
    for (int e = 0; e < N; e++) begin
      act_v[e] = 6'(e * 3);
      code_v[0][e] = 3'b001;
      code_v[1][e] = 3'b101;
    end
    run_main("R10 start busy", 7);
  endtask

  task automatic test_idle_valid();
    int r0;
    r0 = res_o;
    valid_i = 1; act_i = 6'd50; wcode_i = 6'b011011;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      check("R11 idle ready", ready_o, 0);
      check("R11 idle done", done_o, 0);
    end
    check("R11 idle res", res_o, r0);
    valid_i = 0;
  endtask

  task automatic test_ternary();
    int exp;
    exp = 0;
    for (int e = 0; e < N; e++) begin
      tcode_v[e] = 2'(e % 4);
      exp += (e % 4 == 1) ? (e + 2) : ((e % 4 == 3) ? -(e + 2) : 0);
    end
    exp += 0;
    @(negedge clk); t_start = 1;
    @(negedge clk); t_start = 0;
    for (int e = 0; e < N; e++) begin
      t_act = 6'(e + 2); t_code = tcode_v[e]; t_valid = 1;
      #1;
      if (e == 0) check("R3 ternary ready", t_ready, 1);
      @(negedge clk);
    end
    t_valid = 0; #1;
    check("R3 ternary done", t_done, 1);
    check("R3 ternary sum", int'($signed(t_res)), rq(exp, 0, 8));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1;
    test_codes();
    test_random();
    test_full_scale();
    test_zero_codes();
    test_start_busy();
    test_idle_valid();
    test_ternary();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule